// File: doc/BRIEF.md
# Raster Video Controller Register and Interrupt Unit

This block is the processor-facing register file of a raster video controller. It decodes a register address, keeps a 64-byte register image, and returns read data. Some addresses return live values from the rest of the controller instead of stored bytes, and bits or addresses with no function read back as ones. The raster counter, sprite fetch and pixel logic live elsewhere. They supply the current raster line, the latched light-pen position and one-cycle interrupt source pulses.

Four interrupt sources set sticky flag bits. Software clears a flag by writing a one to it, and selects which flags may interrupt through a 4-bit enable mask. A summary bit reports whether the interrupt line is being driven. The interrupt line is a registered, active-high output.

Top module: `vidreg_unit`

## Requirements
- R1: Only the low 6 bits of `addr_i` are decoded. Address `a` and `a + 64*k` reach the same register, for both reads and writes.
- R2: A write stores the full byte at the decoded address. Reading an address in 0x00..0x1F returns that stored byte, except at 0x11, 0x12, 0x13, 0x14 and 0x19, 0x1A.
- R3: Reading an address in 0x20..0x2E returns the stored byte with bits 7..4 forced to 1.
- R4: Reading any address from 0x2F to 0x3F returns 0xFF, whatever was written there.
- R5: Reading 0x11 returns stored bits 6..0, with bit 7 taken from bit 8 of `raster_i`. Reading 0x12 returns `raster_i[7:0]`.
- R6: Reading 0x13 returns `lp_x_i`, and reading 0x14 returns `lp_y_i`.
- R7: Reading 0x19 returns {summary, 1, 1, 1, flags[3:0]}, where the summary bit equals `irq_o`.
- R8: A high `src_i[k]` sets flag bit k on that clock edge. Bit 0 is raster, bit 1 is sprite-to-background collision, bit 2 is sprite-to-sprite collision and bit 3 is light pen.
- R9: Writing 0x19 clears every flag bit 3..0 whose written bit is 1. Flag bits written with 0 are unchanged.
- R10: Writing 0x1A keeps only data bits 3..0 as the enable mask. Reading 0x1A returns {1111, mask}.
- R11: `irq_o` and the summary bit go high on the edge after (flags & mask) becomes nonzero. They go low on the edge after it becomes zero.
- R12: If a source pulse and a clearing write to 0x19 hit the same flag bit in the same cycle, the flag ends up set.
- R13: After reset all stored bytes, flags, mask and `irq_o` are zero. Reading 0x19 gives 0x70 and reading 0x1A gives 0xF0.
- R14: `rdata_o` is 0x00 while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address (low 6 bits decoded) |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, acts on the clock edge |
| rd_i | input | 1 | Read strobe, enables `rdata_o` |
| raster_i | input | 9 | Current raster line |
| lp_x_i | input | 8 | Latched light-pen X |
| lp_y_i | input | 8 | Latched light-pen Y |
| src_i | input | 4 | Interrupt source pulses (raster, sprite-bg, sprite-sprite, light pen) |
| rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Read data is combinational from the address, `rd_i` and current state. It is sampled a few nanoseconds after the read is applied, in the same low clock phase. A write, a source pulse or a mask change takes effect at the next rising edge. Flags, mask, stored bytes, `irq_o` and the summary bit therefore show the change at the falling edge after that edge, and every check is placed there. The collision case drives the pulse and the clearing write in the same cycle and reads the flag one cycle later.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;
  localparam int unsigned AW     = 6;
  localparam int unsigned DW     = 8;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned DEPTH  = 1 << AW;

  localparam logic [AW-1:0] A_CTRL   = 6'h11;
  localparam logic [AW-1:0] A_RASTER = 6'h12;
  localparam logic [AW-1:0] A_LPX    = 6'h13;
  localparam logic [AW-1:0] A_LPY    = 6'h14;
  localparam logic [AW-1:0] A_FLAG   = 6'h19;
  localparam logic [AW-1:0] A_MASK   = 6'h1A;
  localparam logic [AW-1:0] A_NIBBLE = 6'h20;
  localparam logic [AW-1:0] A_ALLONE = 6'h2F;
endpackage

// File: rtl/vidreg_store.sv
module vidreg_store
  import vidreg_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  parameter int unsigned DW_P    = DW,
  localparam int unsigned AW_L   = $clog2(DEPTH_P)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW_L-1:0]   addr_i,
  input  logic [DW_P-1:0]   wdata_i,
  output logic [DW_P-1:0]   rdata_o
);
  logic [DW_P-1:0] mem_q [DEPTH_P];

  for (genvar i = 0; i < DEPTH_P; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (we_i && addr_i == AW_L'(i))         mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/vidreg_irq.sv
module vidreg_irq
  import vidreg_pkg::*;
#(
  parameter int unsigned NSRC_P = NSRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC_P-1:0] src_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic [NSRC_P-1:0] wbits_i,
  output logic [NSRC_P-1:0] flags_o,
  output logic [NSRC_P-1:0] mask_o,
  output logic              irq_o
);
  logic [NSRC_P-1:0] flags_q, flags_d, mask_q, mask_d, clr;
  logic              irq_q;

  assign clr     = clr_we_i ? wbits_i : '0;
  assign flags_d = (flags_q & ~clr) | src_i;   // source wins over clear
  assign mask_d  = mask_we_i ? wbits_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_q   <= |(flags_d & mask_d);
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  AST_SRC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((flags_q & $past(src_i)) == $past(src_i)));  // R8 R12
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && src_i == '0) |=> ((flags_q & $past(wbits_i)) == '0));  // R9
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && src_i == '0) |=> $stable(flags_q));  // R9
  AST_IRQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == |(flags_q & mask_q));  // R11
  AST_NO_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_q);  // R10
endmodule

// File: rtl/vidreg_rdmux.sv
module vidreg_rdmux
  import vidreg_pkg::*;
(
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   stored_i,
  input  logic [8:0]      raster_i,
  input  logic [DW-1:0]   lp_x_i,
  input  logic [DW-1:0]   lp_y_i,
  input  logic [NSRC-1:0] flags_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            irq_i,
  output logic [DW-1:0]   rdata_o
);
  logic [DW-1:0] val;

  always_comb begin
    unique case (addr_i)
      A_CTRL:   val = {raster_i[8], stored_i[6:0]};
      A_RASTER: val = raster_i[7:0];
      A_LPX:    val = lp_x_i;
      A_LPY:    val = lp_y_i;
      A_FLAG:   val = {irq_i, 3'b111, flags_i};
      A_MASK:   val = {4'hF, mask_i};
      default: begin
        if (addr_i < A_NIBBLE)      val = stored_i;
        else if (addr_i < A_ALLONE) val = stored_i | 8'hF0;
        else                        val = 8'hFF;
      end
    endcase
  end

  assign rdata_o = rd_i ? val : '0;
endmodule

// File: rtl/vidreg_unit.sv
module vidreg_unit
  import vidreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [8:0]        raster_i,
  input  logic [7:0]        lp_x_i,
  input  logic [7:0]        lp_y_i,
  input  logic [3:0]        src_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  logic [AW-1:0]   a;
  logic            unused_hi;
  logic [DW-1:0]   stored;
  logic [NSRC-1:0] flags, mask;
  logic            irq;

  assign a         = addr_i[AW-1:0];   // 64-byte window repeats
  assign unused_hi = ^addr_i[ADDR_W-1:AW];

  vidreg_store #(.DEPTH_P(DEPTH), .DW_P(DW)) u_store (
    .clk_i, .rst_ni,
    .we_i   (wr_i),
    .addr_i (a),
    .wdata_i,
    .rdata_o(stored)
  );

  vidreg_irq #(.NSRC_P(NSRC)) u_irq (
    .clk_i, .rst_ni,
    .src_i,
    .clr_we_i (wr_i && a == A_FLAG),
    .mask_we_i(wr_i && a == A_MASK),
    .wbits_i  (wdata_i[NSRC-1:0]),
    .flags_o  (flags),
    .mask_o   (mask),
    .irq_o    (irq)
  );

  vidreg_rdmux u_rdmux (
    .rd_i,
    .addr_i  (a),
    .stored_i(stored),
    .raster_i,
    .lp_x_i,
    .lp_y_i,
    .flags_i (flags),
    .mask_i  (mask),
    .irq_i   (irq),
    .rdata_o
  );

  assign irq_o = irq;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'h00));  // R14
endmodule

// File: tb/vidreg_unit_test.sv
`timescale 1ns/1ps
module vidreg_unit_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic       wr = 0, rd = 0;
  logic [8:0] raster = 0;
  logic [7:0] lpx = 0, lpy = 0;
  logic [3:0] src = 0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  vidreg_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .raster_i(raster), .lp_x_i(lpx), .lp_y_i(lpy),
    .src_i(src), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    addr = a; rd = 1; #2;
    chk(req, rdata, exp);
    rd = 0; #1;
  endtask

  task automatic pulse(logic [3:0] m);
    @(negedge clk); src = m;
    @(negedge clk); src = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R13 irq", {7'd0, irq}, 8'h00);
    rd_chk("R13 flags", 8'h19, 8'h70);
    rd_chk("R13 mask", 8'h1A, 8'hF0);
    rd_chk("R13 byte", 8'h05, 8'h00);
    addr = 8'h19; #2; chk("R14 idle", rdata, 8'h00);
  endtask

  task automatic t_plain;
    wr_reg(8'h05, 8'hA5); rd_chk("R2 05", 8'h05, 8'hA5);
    wr_reg(8'h1F, 8'h3C); rd_chk("R2 1F", 8'h1F, 8'h3C);
  endtask

  task automatic t_alias;
    wr_reg(8'hC3, 8'h5A);
    rd_chk("R1 alias 03", 8'h03, 8'h5A);
    rd_chk("R1 alias 43", 8'h43, 8'h5A);
  endtask

  task automatic t_nibble;
    wr_reg(8'h21, 8'h0C); rd_chk("R3 21", 8'h21, 8'hFC);
    wr_reg(8'h2E, 8'h31); rd_chk("R3 2E", 8'h2E, 8'hF1);
  endtask

  task automatic t_allone;
    wr_reg(8'h2F, 8'h00); rd_chk("R4 2F", 8'h2F, 8'hFF);
    wr_reg(8'h3F, 8'h12); rd_chk("R4 3F", 8'h3F, 8'hFF);
  endtask

  task automatic t_live;
    wr_reg(8'h11, 8'h05);
    raster = 9'h1AB; #1;
    rd_chk("R5 ctrl hi", 8'h11, 8'h85);
    rd_chk("R5 raster", 8'h12, 8'hAB);
    raster = 9'h0C4; #1;
    rd_chk("R5 ctrl lo", 8'h11, 8'h05);
    rd_chk("R5 raster2", 8'h12, 8'hC4);
    lpx = 8'h9E; lpy = 8'h37; #1;
    rd_chk("R6 lpx", 8'h13, 8'h9E);
    rd_chk("R6 lpy", 8'h14, 8'h37);
  endtask

  task automatic t_irq;
    pulse(4'b0001);
    rd_chk("R8 raster flag", 8'h19, 8'h71);
    chk("R11 no mask", {7'd0, irq}, 8'h00);
    wr_reg(8'h1A, 8'hF1);
    rd_chk("R10 mask", 8'h1A, 8'hF1);
    chk("R11 irq on", {7'd0, irq}, 8'h01);
    rd_chk("R7 summary", 8'h19, 8'hF1);
    pulse(4'b1100);
    rd_chk("R8 bits 2,3", 8'h19, 8'hFD);
    wr_reg(8'h19, 8'h01);
    rd_chk("R9 clear 0", 8'h19, 8'h7C);
    chk("R11 irq off", {7'd0, irq}, 8'h00);
    wr_reg(8'h19, 8'h04);
    rd_chk("R9 clear 2", 8'h19, 8'h78);
    wr_reg(8'h1A, 8'h08);
    chk("R11 irq lp", {7'd0, irq}, 8'h01);
    wr_reg(8'h1A, 8'h00);
    chk("R11 unmask off", {7'd0, irq}, 8'h00);
    rd_chk("R7 flags kept", 8'h19, 8'h78);
  endtask

  task automatic t_race;
    pulse(4'b0010);
    rd_chk("R8 bit1", 8'h19, 8'h7A);
    @(negedge clk); addr = 8'h19; wdata = 8'h0A; wr = 1; src = 4'b0010;
    @(negedge clk); wr = 0; src = 0;
    rd_chk("R12 src wins", 8'h19, 8'h72);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_plain; t_alias; t_nibble; t_allone; t_live; t_irq; t_race;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule